// File: doc/BRIEF.md
# Demand-Mode Attribute Stream Processor

This block sits between a display fetch engine and a row buffer. It consumes a stream of 16-bit words. A character word carries two 8-bit character codes. The block writes each code into the next row-buffer slot, together with the display attribute currently in force. Attributes are not fetched per character. A character code that equals the programmed flag value announces that the next consumed word is an attribute word. That attribute either stays in force for all later characters (latched) or covers one character only (one-shot).

Configuration inputs choose several behaviours. They select whether the flag character is itself displayed and which byte of a character word is emitted first. They decide whether characters marked as hidden are written anyway, and whether the row holds 96 or 132 entries. A row-start pulse rewinds the write slot for the next row. When the row is full, the input handshake stalls, so no fetched word is lost.

Top module: `attr_stream_proc`

## Requirements
- R1: After reset, in_ready is 1 and wr_en is 0. The latched attribute is all zeros, so characters written before any attribute word carry wr_attr = 0.
- R2: A word accepted with in_text = 1 gives two codes, written to consecutive slots starting at the current slot. With cfg_swap = 0, bits [7:0] come first. With cfg_swap = 1, bits [15:8] come first.
- R3: A code equal to cfg_flag makes the next accepted word an attribute word, whatever its in_text value. Bit fields of that word: [11:0] are the display bits driven on wr_attr, [12] is the ignore bit, [13] is the latched bit, and [15:14] have no effect. cfg_swap does not reorder an attribute word.
- R4: An attribute word with bit 13 set becomes the attribute for every later character that does not invoke one.
- R5: An attribute word with bit 13 clear applies to one character only. After that character, the most recent latched attribute is back in force.
- R6: With cfg_invis = 0, the flag code is itself written, carrying the newly invoked attribute. Every flag code is processed, including two in one word.
- R7: With cfg_invis = 1, the flag code is not written and the invoked attribute applies to the following character.
- R8: With cfg_invis = 1, only the first flag code of a character word acts as a flag. A second flag code in the same word is written as an ordinary character. Flags in different words each invoke an attribute.
- R9: A character whose attribute has bit 12 set is not written and takes no slot while cfg_show_hidden = 0. With cfg_show_hidden = 1, it is written normally. Bits 12 and 13 never appear on wr_attr.
- R10: The row holds slots 0..95 when cfg_narrow = 1 and slots 0..131 when cfg_narrow = 0. When the row is full, in_ready goes low and pending characters wait without loss until row_start.
- R11: row_start resets the write slot to 0. A write that would fall in the row_start cycle is held and goes to slot 0 in the next cycle.
- R12: A word with in_text = 0 that arrives while no attribute is pending is consumed and discarded.
- R13: A word is taken only in a cycle where in_valid and in_ready are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| row_start | input | 1 | Pulse that rewinds the write slot to 0 |
| cfg_flag | input | 8 | Code value that invokes an attribute |
| cfg_invis | input | 1 | 1: flag code is not written |
| cfg_swap | input | 1 | 1: high byte of a character word first |
| cfg_show_hidden | input | 1 | 1: write characters marked hidden |
| cfg_narrow | input | 1 | 1: 96 slots per row, 0: 132 slots |
| in_valid | input | 1 | Word on in_word is valid |
| in_ready | output | 1 | Block takes the word this cycle |
| in_word | input | 16 | Fetched word |
| in_text | input | 1 | 1: character word, 0: other data |
| wr_en | output | 1 | Row-buffer write strobe |
| wr_addr | output | 8 | Row-buffer slot |
| wr_char | output | 8 | Character code written |
| wr_attr | output | 12 | Display attribute written |

## Verification
The two functions that can meet in one cycle are the row-start rewind and a character write that is ready to go out. The bench accepts a character word and raises row_start in exactly the cycle in which the first code of that word would be written. It then checks three things: no write appears in that cycle, the held code lands in slot 0 one cycle later, and its partner lands in slot 1. A second collision happens on a full row. There a word held on the input is accepted only after the rewind, and both of its codes must reach slots 0 and 1 with none lost.

// File: rtl/attr_stream_proc.sv
module attr_stream_proc #(
  parameter int CODE_W     = 8,
  parameter int ATTR_W     = 12,
  parameter int WIDE_LEN   = 132,
  parameter int NARROW_LEN = 96,
  localparam int WORD_W    = 2 * CODE_W,
  localparam int IDX_W     = $clog2(WIDE_LEN + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              row_start,
  input  logic [CODE_W-1:0] cfg_flag,
  input  logic              cfg_invis,
  input  logic              cfg_swap,
  input  logic              cfg_show_hidden,
  input  logic              cfg_narrow,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic              in_text,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [CODE_W-1:0] wr_char,
  output logic [ATTR_W-1:0] wr_attr
);

  localparam int IGN_BIT = ATTR_W;
  localparam int LAT_BIT = ATTR_W + 1;

  logic [CODE_W-1:0] q0, q1;
  logic [1:0]        q_cnt;
  logic              armed, flag_seen, pend;
  logic [ATTR_W:0]   latched_a, shot_a;
  logic              shot_v;
  logic [IDX_W-1:0]  idx;

  logic [IDX_W-1:0]  cap;
  logic              full, take, act, is_flag, hidden, ch_go, pop;
  logic [ATTR_W:0]   use_a;
  logic              unused_hi;

  assign cap      = cfg_narrow ? IDX_W'(NARROW_LEN) : IDX_W'(WIDE_LEN);
  assign full     = idx >= cap;
  assign in_ready = pend | (q_cnt == 2'd0 && !full);
  assign take     = in_valid & in_ready;

  assign act      = (q_cnt != 2'd0) & ~pend & ~row_start;
  assign is_flag  = act & (q0 == cfg_flag) & ~armed & ~(cfg_invis & flag_seen);
  assign use_a    = shot_v ? shot_a : latched_a;
  assign hidden   = use_a[IGN_BIT] & ~cfg_show_hidden;
  assign ch_go    = act & ~is_flag & (hidden | ~full);
  assign pop      = ch_go | (is_flag & cfg_invis);

  assign wr_en    = ch_go & ~hidden;
  assign wr_addr  = idx;
  assign wr_char  = q0;
  assign wr_attr  = use_a[ATTR_W-1:0];

  assign unused_hi = ^in_word[WORD_W-1:LAT_BIT+1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q0 <= '0; q1 <= '0; q_cnt <= '0;
      armed <= 1'b0; flag_seen <= 1'b0; pend <= 1'b0;
      latched_a <= '0; shot_a <= '0; shot_v <= 1'b0;
      idx <= '0;
    end else begin
      if (row_start)  idx <= '0;
      else if (wr_en) idx <= idx + 1'b1;

      if (take) begin
        if (pend) begin
          pend <= 1'b0;
          if (in_word[LAT_BIT]) begin
            latched_a <= in_word[ATTR_W:0];
            shot_v    <= 1'b0;
          end else begin
            shot_a <= in_word[ATTR_W:0];
            shot_v <= 1'b1;
          end
        end else if (in_text) begin
          q0        <= cfg_swap ? in_word[WORD_W-1:CODE_W] : in_word[CODE_W-1:0];
          q1        <= cfg_swap ? in_word[CODE_W-1:0] : in_word[WORD_W-1:CODE_W];
          q_cnt     <= 2'd2;
          flag_seen <= 1'b0;
          armed     <= 1'b0;
        end
      end

      if (is_flag) begin
        pend <= 1'b1;
        if (cfg_invis) flag_seen <= 1'b1;
        else           armed     <= 1'b1;
      end

      if (ch_go) shot_v <= 1'b0;

      if (pop) begin
        q0    <= q1;
        q_cnt <= q_cnt - 2'd1;
        armed <= 1'b0;
      end
    end
  end

endmodule

module attr_stream_proc_chk #(
  parameter int WIDE_LEN   = 132,
  parameter int NARROW_LEN = 96,
  parameter int IDX_W      = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             row_start,
  input logic             cfg_narrow,
  input logic             wr_en,
  input logic [IDX_W-1:0] wr_addr
);

  p_addr_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> int'(wr_addr) < (cfg_narrow ? NARROW_LEN : WIDE_LEN));

  p_no_write_on_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
    row_start |-> !wr_en);

  p_restart_slot0_r11: assert property (@(posedge clk) disable iff (!rst_n)
    row_start ##1 wr_en |-> wr_addr == '0);

  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en ##1 wr_en |-> wr_addr == $past(wr_addr) + 1'b1);

endmodule

bind attr_stream_proc attr_stream_proc_chk #(
  .WIDE_LEN(WIDE_LEN), .NARROW_LEN(NARROW_LEN), .IDX_W(IDX_W)
) chk_i (.*);

// File: tb/attr_stream_proc_tb.sv
module attr_stream_proc_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        row_start = 1'b0;
  logic [7:0]  cfg_flag = 8'hFE;
  logic        cfg_invis = 1'b0, cfg_swap = 1'b0, cfg_show_hidden = 1'b0, cfg_narrow = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_word = '0;
  logic        in_text = 1'b0;
  logic        wr_en;
  logic [7:0]  wr_addr;
  logic [7:0]  wr_char;
  logic [11:0] wr_attr;

  attr_stream_proc dut_i (
    .clk(clk), .rst_n(rst_n), .row_start(row_start),
    .cfg_flag(cfg_flag), .cfg_invis(cfg_invis), .cfg_swap(cfg_swap),
    .cfg_show_hidden(cfg_show_hidden), .cfg_narrow(cfg_narrow),
    .in_valid(in_valid), .in_ready(in_ready), .in_word(in_word), .in_text(in_text),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_char(wr_char), .wr_attr(wr_attr)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  int log_v[0:511];
  int log_n = 0;
  int exp_v[0:511];
  int exp_n = 0;

  always begin
    @(negedge clk);
    #2;
    if (rst_n && wr_en && log_n < 512) begin
      log_v[log_n] = (int'(wr_addr) << 20) | (int'(wr_char) << 12) | int'(wr_attr);
      log_n = log_n + 1;
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic ex(input int a, input int c, input int at);
    exp_v[exp_n] = (a << 20) | (c << 12) | at;
    exp_n++;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; row_start = 1'b0; in_valid = 1'b0; in_text = 1'b0; in_word = '0;
    cfg_flag = 8'hFE; cfg_invis = 1'b0; cfg_swap = 1'b0; cfg_show_hidden = 1'b0; cfg_narrow = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    log_n = 0; exp_n = 0;
  endtask

  task automatic send(input logic [15:0] w, input logic t);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_text = t;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic compare(input string req);
    idle(8);
    chk(req, "write count", log_n, exp_n);
    for (int i = 0; i < exp_n && i < log_n; i++)
      chk(req, $sformatf("write %0d addr/char/attr", i), log_v[i], exp_v[i]);
    log_n = 0; exp_n = 0;
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    // R1 reset state
    do_reset();
    chk("R1", "in_ready", int'(in_ready), 1);
    chk("R1", "wr_en", int'(wr_en), 0);
    // R2 low byte first, R1 zero attribute
    send(16'h4241, 1'b1); send(16'h4443, 1'b1);
    ex(0, 'h41, 0); ex(1, 'h42, 0); ex(2, 'h43, 0); ex(3, 'h44, 0);
    compare("R1 R2");

    // R2 high byte first
    do_reset(); cfg_swap = 1'b1;
    send(16'h4241, 1'b1); send(16'h4443, 1'b1);
    ex(0, 'h42, 0); ex(1, 'h41, 0); ex(2, 'h44, 0); ex(3, 'h43, 0);
    compare("R2");

    // R3 R4 latched attribute, swap leaves attribute word alone
    do_reset(); cfg_invis = 1'b1; cfg_swap = 1'b1;
    send(16'hFE41, 1'b1); send(16'h2123, 1'b1);
    send(16'h4342, 1'b1);
    ex(0, 'h41, 'h123); ex(1, 'h43, 'h123); ex(2, 'h42, 'h123);
    compare("R3 R4");

    // R5 R7 one-shot then revert
    do_reset(); cfg_invis = 1'b1;
    send(16'h41FE, 1'b1); send(16'h2010, 1'b1);
    send(16'h42FE, 1'b1); send(16'h0055, 1'b1);
    send(16'h4443, 1'b1);
    ex(0, 'h41, 'h010); ex(1, 'h42, 'h055); ex(2, 'h43, 'h010); ex(3, 'h44, 'h010);
    compare("R5 R7");

    // R6 visible flag
    do_reset();
    send(16'h41FE, 1'b1); send(16'h2077, 1'b1);
    send(16'h42FE, 1'b1); send(16'h0005, 1'b1);
    ex(0, 'hFE, 'h077); ex(1, 'h41, 'h077); ex(2, 'hFE, 'h005); ex(3, 'h42, 'h077);
    compare("R6");

    // R6 two visible flags in one word
    do_reset();
    send(16'hFEFE, 1'b1); send(16'h0031, 1'b1); send(16'h0032, 1'b1);
    ex(0, 'hFE, 'h031); ex(1, 'hFE, 'h032);
    compare("R6");

    // R8 dedup within a word, both across words
    do_reset(); cfg_invis = 1'b1;
    send(16'hFEFE, 1'b1); send(16'h0011, 1'b1);
    send(16'h4241, 1'b1);
    send(16'h43FE, 1'b1); send(16'h0021, 1'b1);
    send(16'h44FE, 1'b1); send(16'h0022, 1'b1);
    ex(0, 'hFE, 'h011); ex(1, 'h41, 0); ex(2, 'h42, 0); ex(3, 'h43, 'h021); ex(4, 'h44, 'h022);
    compare("R8");

    // R9 hidden characters take no slot; bits 15:14 inert
    do_reset(); cfg_invis = 1'b1;
    send(16'h41FE, 1'b1); send(16'h3005, 1'b1);
    send(16'h4342, 1'b1);
    send(16'h44FE, 1'b1); send(16'hE006, 1'b1);
    ex(0, 'h44, 'h006);
    compare("R9");

    // R9 show hidden
    do_reset(); cfg_invis = 1'b1; cfg_show_hidden = 1'b1;
    send(16'h41FE, 1'b1); send(16'h3005, 1'b1);
    ex(0, 'h41, 'h005);
    compare("R9");

    // R12 non-text dropped; R3 attribute taken regardless of in_text
    do_reset(); cfg_invis = 1'b1;
    send(16'h4241, 1'b0);
    send(16'h43FE, 1'b1); send(16'h2009, 1'b0);
    ex(0, 'h43, 'h009);
    compare("R12 R3");

    // R10 R13 narrow row, full stall, no loss
    do_reset(); cfg_flag = 8'hFF; cfg_narrow = 1'b1;
    for (int w = 0; w < 48; w++) send(16'((2*w+1) << 8 | (2*w)), 1'b1);
    idle(6);
    chk("R10", "in_ready when narrow row full", int'(in_ready), 0);
    chk("R10", "writes in narrow row", log_n, 96);
    @(negedge clk);
    in_valid = 1'b1; in_word = 16'h6160; in_text = 1'b1;
    idle(4);
    chk("R13", "word held while full", int'(in_ready), 0);
    chk("R10", "no write while full", log_n, 96);
    row_start = 1'b1;
    @(negedge clk);
    row_start = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    for (int i = 0; i < 96; i++) ex(i, i, 0);
    ex(0, 'h60, 0); ex(1, 'h61, 0);
    compare("R10 R13");

    // R10 wide row
    do_reset(); cfg_flag = 8'hFF;
    for (int w = 0; w < 66; w++) send(16'((2*w+1) << 8 | (2*w)), 1'b1);
    idle(6);
    chk("R10", "in_ready when wide row full", int'(in_ready), 0);
    for (int i = 0; i < 132; i++) ex(i, i, 0);
    compare("R10");

    // R11 row_start collides with a pending write
    do_reset();
    send(16'h4241, 1'b1);
    idle(4);
    in_valid = 1'b1; in_word = 16'h4443; in_text = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; row_start = 1'b1;
    #2;
    chk("R11", "no write in row_start cycle", int'(wr_en), 0);
    @(negedge clk);
    row_start = 1'b0;
    ex(0, 'h41, 0); ex(1, 'h42, 0); ex(0, 'h43, 0); ex(1, 'h44, 0);
    compare("R11");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule